// File: doc/BRIEF.md
# Differential Serial Line Codec with NRZI and Bit Stuffing

This block sits between a byte-wide packet interface and a two-wire differential serial line. On the send side it takes a stream of bytes and marks the final byte. It puts an eight-bit synchronisation preamble in front of the packet and sends each byte least-significant bit first. After any six consecutive ones it adds a zero, and it encodes every bit as a transition or no transition on the wire. It closes the packet with two bit times of both wires low and one bit time of the idle level. When asked, it can also hold both wires low for a configurable number of bit times, which signals a bus reset.

On the receive side it watches the same kind of line, finds the preamble and decodes the transitions. It drops the inserted zeros, rebuilds bytes, and reports the start of a packet, each byte, the end of a packet, and any run of ones longer than the stuffing rule allows. Both directions advance by one bit on each cycle where the bit enable input is high. The line inputs are assumed to be already synchronous to the clock, and each one is sampled once per bit time.

Top module: `diffline_codec`

## Requirements
- R1: After reset, and whenever the transmitter is not driving, the line outputs show the idle level J (`line_dp_o`=1, `line_dm_o`=0) with `line_oe`=0. The receiver pulses are all low and `rx_active`=0.
- R2: Each transmitted packet starts from J with a preamble that decodes to seven 0 bits followed by one 1 bit. A 0 toggles the line level and a 1 keeps it.
- R3: After the preamble, each byte is sent least-significant bit first using the same level encoding.
- R4: The trailing 1 of the preamble counts toward the run. After six consecutive 1s the transmitter inserts a 0, including after the final data bit, so the wire never carries more than six 1s in a row.
- R5: A packet ends with exactly two bit times of both wires low (`line_oe`=1), then one bit time of J with `line_oe`=1, then release (`line_oe`=0).
- R6: When `bus_reset_req` is high on a bit tick while the transmitter is idle, both wires are driven low for exactly RESET_TICKS bit times, and then the line is released.
- R7: A byte is taken in the cycle where `tx_ready`=1. The first byte is taken on the tick that starts the preamble. Each later byte is taken on the tick that sends the last bit of the previous one, unless that byte had `tx_last`=1.
- R8: The receiver pulses `rx_sop` and raises `rx_active` after it decodes at least six 0 bits followed by a 1.
- R9: Inside a packet the receiver drops the bit that follows six 1s. It assembles the remaining bits LSB first and pulses `rx_valid` with the byte in `rx_data` once eight bits have been collected.
- R10: A sample with both wires low inside a packet pulses `rx_eop` and ends the packet.
- R11: If the bit after six 1s is a 1, the receiver pulses `rx_stuff_err`, leaves the packet (`rx_active`=0), and delivers no partial byte.
- R12: Line outputs and receiver state change only on cycles where `bit_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per bit time |
| tx_valid | input | 1 | A byte is offered on `tx_data` |
| tx_data | input | DATA_W | Byte to send |
| tx_last | input | 1 | The offered byte is the final one of the packet |
| tx_ready | output | 1 | The offered byte is taken this cycle |
| bus_reset_req | input | 1 | Request a bus reset pulse |
| line_dp_o | output | 1 | Positive wire, transmit |
| line_dm_o | output | 1 | Negative wire, transmit |
| line_oe | output | 1 | Transmitter drives the wires |
| line_dp_i | input | 1 | Positive wire, receive |
| line_dm_i | input | 1 | Negative wire, receive |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | `rx_data` holds a new byte (one cycle) |
| rx_sop | output | 1 | Preamble found (one cycle) |
| rx_eop | output | 1 | End of packet found (one cycle) |
| rx_stuff_err | output | 1 | Stuffing violation (one cycle) |
| rx_active | output | 1 | Receiver is inside a packet |

## Verification
The hardest receive case to reach is a stuffing violation, because the transmitter in this block never produces one. A loopback setup alone can therefore never reach it. The bench switches the receive wires to its own driver and plays a preamble followed by seven held levels, which should raise the error. It then plays a correct stuffed 0xFF byte on the same path, which shows that the dropped bit is removed. The transmit boundary where stuffing is needed right before the end marker is reached with a byte whose top six bits are ones.

// File: rtl/diffline_pkg.sv
// Shared constants and state types for the differential line codec.
package diffline_pkg;
    // Longest run of ones allowed on the wire before a zero is forced.
    localparam int STUFF_RUN      = 6;
    // Minimum count of zero bits the receiver needs before the closing one.
    localparam int SYNC_ZEROS_MIN = 6;

    typedef enum logic [2:0] {
        TX_IDLE, TX_SYNC, TX_DATA, TX_SE0, TX_JEND, TX_RST
    } tx_state_e;

    typedef enum logic [0:0] {
        RX_HUNT, RX_DATA
    } rx_state_e;
endpackage

// File: rtl/diffline_tx.sv
// Transmit path: preamble, LSB-first serialisation, zero insertion,
// transition encoding, end marker and bus reset pulse.
// Assumes bit_en is a single-cycle pulse per bit time. A byte source that
// has nothing ready at a byte boundary ends the packet there.
module diffline_tx
    import diffline_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int RESET_TICKS = 120000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_last,
    input  logic              bus_reset_req,
    output logic              tx_ready,
    output logic              line_dp,
    output logic              line_dm,
    output logic              line_oe
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);
    localparam int RST_W = $clog2(RESET_TICKS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         st_q;
    logic [DATA_W-1:0] shreg_q;
    logic              last_q;
    logic              have_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RUN_W-1:0]  ones_q;
    logic [2:0]        sync_q;
    logic [RST_W-1:0]  rcnt_q;
    logic              dp_q, dm_q, oe_q;

    logic stuff_now, byte_end, take_first, take_next, cur_bit;

    // Decide this tick's action: forced zero, byte boundary or byte intake.
    always_comb begin
        stuff_now  = (st_q == TX_DATA) && (ones_q == RUN_W'(STUFF_RUN));
        byte_end   = (st_q == TX_DATA) && !stuff_now && have_q && (idx_q == LAST_IDX);
        take_first = (st_q == TX_IDLE) && !bus_reset_req && tx_valid;
        take_next  = byte_end && !last_q && tx_valid;
        tx_ready   = bit_en && (take_first || take_next);
        cur_bit    = shreg_q[idx_q];
    end

    // Sequencer and line registers, advanced once per bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= TX_IDLE;
            shreg_q <= '0;
            last_q  <= 1'b0;
            have_q  <= 1'b0;
            idx_q   <= '0;
            ones_q  <= '0;
            sync_q  <= '0;
            rcnt_q  <= '0;
            dp_q    <= 1'b1;
            dm_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (bit_en) begin
            unique case (st_q)
                TX_IDLE: begin
                    dp_q <= 1'b1;
                    dm_q <= 1'b0;
                    oe_q <= 1'b0;
                    if (bus_reset_req) begin
                        st_q   <= TX_RST;
                        dp_q   <= 1'b0;
                        dm_q   <= 1'b0;
                        oe_q   <= 1'b1;
                        rcnt_q <= RST_W'(1);
                    end else if (tx_valid) begin
                        shreg_q <= tx_data;
                        last_q  <= tx_last;
                        have_q  <= 1'b1;
                        idx_q   <= '0;
                        sync_q  <= 3'd1;
                        st_q    <= TX_SYNC;
                        dp_q    <= 1'b0;   // first preamble zero: J to K
                        dm_q    <= 1'b1;
                        oe_q    <= 1'b1;
                    end
                end
                TX_SYNC: begin
                    if (sync_q == 3'd7) begin
                        st_q   <= TX_DATA;
                        ones_q <= RUN_W'(1);
                    end else begin
                        dp_q <= ~dp_q;
                        dm_q <= dp_q;
                    end
                    sync_q <= sync_q + 3'd1;
                end
                TX_DATA: begin
                    if (stuff_now) begin
                        dp_q   <= ~dp_q;
                        dm_q   <= dp_q;
                        ones_q <= '0;
                    end else if (!have_q) begin
                        st_q <= TX_SE0;
                        dp_q <= 1'b0;
                        dm_q <= 1'b0;
                    end else begin
                        if (cur_bit) begin
                            ones_q <= ones_q + RUN_W'(1);
                        end else begin
                            dp_q   <= ~dp_q;
                            dm_q   <= dp_q;
                            ones_q <= '0;
                        end
                        if (idx_q == LAST_IDX) begin
                            idx_q <= '0;
                            if (take_next) begin
                                shreg_q <= tx_data;
                                last_q  <= tx_last;
                            end else begin
                                have_q <= 1'b0;
                            end
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                TX_SE0: begin
                    st_q <= TX_JEND;
                end
                TX_JEND: begin
                    st_q <= TX_IDLE;
                    dp_q <= 1'b1;
                    dm_q <= 1'b0;
                    oe_q <= 1'b1;
                end
                TX_RST: begin
                    if (rcnt_q == RST_W'(RESET_TICKS)) begin
                        st_q <= TX_IDLE;
                        dp_q <= 1'b1;
                        dm_q <= 1'b0;
                        oe_q <= 1'b0;
                    end else begin
                        rcnt_q <= rcnt_q + RST_W'(1);
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign line_dp = dp_q;
    assign line_dm = dm_q;
    assign line_oe = oe_q;

    // Released wires must rest at J.
    p_released_is_j_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> (line_dp && !line_dm));

    // A forced zero always produces a transition on the wire.
    p_stuff_toggles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st_q == TX_DATA && ones_q == RUN_W'(STUFF_RUN)) |=> (line_dp != $past(line_dp)));

    // During the reset pulse both wires are low and the count stays in range.
    p_reset_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TX_RST) |-> (!line_dp && !line_dm && line_oe && rcnt_q <= RST_W'(RESET_TICKS)));

    // The line holds still between bit ticks.
    p_hold_between_ticks_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({line_dp, line_dm, line_oe}));
endmodule

// File: rtl/diffline_rx.sv
// Receive path: preamble search, transition decoding, zero removal,
// byte assembly, end marker detection and stuffing violation report.
// Assumes the wire inputs are already synchronous and sampled once per tick.
module diffline_rx
    import diffline_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              line_dp,
    input  logic              line_dm,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_stuff_err,
    output logic              rx_active
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int RUN_W = $clog2(STUFF_RUN + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_e         st_q;
    logic              prev_q;
    logic [2:0]        zeros_q;
    logic [RUN_W-1:0]  ones_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sreg_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q, sop_q, eop_q, err_q;

    logic se0, dbit;
    logic [DATA_W-1:0] sreg_nx;

    // Classify the current sample and form the next shift value.
    always_comb begin
        se0     = !line_dp && !line_dm;
        dbit    = (line_dp == prev_q);
        sreg_nx = {dbit, sreg_q[DATA_W-1:1]};
    end

    // Receive sequencer; the report pulses last one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_HUNT;
            prev_q  <= 1'b1;
            zeros_q <= '0;
            ones_q  <= '0;
            idx_q   <= '0;
            sreg_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            sop_q   <= 1'b0;
            eop_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            sop_q   <= 1'b0;
            eop_q   <= 1'b0;
            err_q   <= 1'b0;
            if (bit_en) begin
                if (se0) begin
                    prev_q  <= 1'b1;
                    zeros_q <= '0;
                    if (st_q == RX_DATA) begin
                        eop_q <= 1'b1;
                        st_q  <= RX_HUNT;
                    end
                end else begin
                    prev_q <= line_dp;
                    unique case (st_q)
                        RX_HUNT: begin
                            if (!dbit) begin
                                if (zeros_q != 3'd7) zeros_q <= zeros_q + 3'd1;
                            end else begin
                                zeros_q <= '0;
                                if (zeros_q >= 3'(SYNC_ZEROS_MIN)) begin
                                    st_q   <= RX_DATA;
                                    sop_q  <= 1'b1;
                                    ones_q <= RUN_W'(1);
                                    idx_q  <= '0;
                                end
                            end
                        end
                        RX_DATA: begin
                            if (ones_q == RUN_W'(STUFF_RUN)) begin
                                ones_q <= '0;
                                if (dbit) begin
                                    err_q <= 1'b1;
                                    st_q  <= RX_HUNT;
                                end
                            end else begin
                                sreg_q <= sreg_nx;
                                ones_q <= dbit ? ones_q + RUN_W'(1) : '0;
                                if (idx_q == LAST_IDX) begin
                                    idx_q   <= '0;
                                    data_q  <= sreg_nx;
                                    valid_q <= 1'b1;
                                end else begin
                                    idx_q <= idx_q + IDX_W'(1);
                                end
                            end
                        end
                        default: st_q <= RX_HUNT;
                    endcase
                end
            end
        end
    end

    assign rx_data      = data_q;
    assign rx_valid     = valid_q;
    assign rx_sop       = sop_q;
    assign rx_eop       = eop_q;
    assign rx_stuff_err = err_q;
    assign rx_active    = (st_q == RX_DATA);

    // Finding the preamble enters a packet.
    p_sop_enters_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sop |-> rx_active);

    // At most one report per cycle.
    p_reports_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_sop, rx_eop, rx_stuff_err}));

    // A byte is only delivered from inside a packet.
    p_byte_in_packet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_active);

    // A violation leaves the packet.
    p_err_leaves_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stuff_err |-> !rx_active);

    // Receiver state holds between bit ticks.
    p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable({rx_active, data_q}));
endmodule

// File: rtl/diffline_codec.sv
// Top of the line codec: one transmit path and one receive path sharing a
// bit enable. The paths are independent; a loopback is formed outside.
module diffline_codec #(
    parameter int DATA_W      = 8,
    parameter int RESET_TICKS = 120000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_ready,
    input  logic              bus_reset_req,
    output logic              line_dp_o,
    output logic              line_dm_o,
    output logic              line_oe,
    input  logic              line_dp_i,
    input  logic              line_dm_i,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_sop,
    output logic              rx_eop,
    output logic              rx_stuff_err,
    output logic              rx_active
);
    diffline_tx #(.DATA_W(DATA_W), .RESET_TICKS(RESET_TICKS)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .bus_reset_req(bus_reset_req), .tx_ready(tx_ready),
        .line_dp(line_dp_o), .line_dm(line_dm_o), .line_oe(line_oe)
    );

    diffline_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .line_dp(line_dp_i), .line_dm(line_dm_i),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_stuff_err(rx_stuff_err), .rx_active(rx_active)
    );
endmodule

// File: tb/test_diffline_codec.sv
`timescale 1ns/1ps
module test_diffline_codec;
    localparam int W     = 8;
    localparam int RST_T = 24;
    localparam int NV    = 5;

    localparam logic [7:0] VEC_B [0:4][0:3] = '{
        '{8'hA5, 8'h00, 8'h00, 8'h00},
        '{8'hFF, 8'hFF, 8'h00, 8'h00},
        '{8'h00, 8'h3C, 8'h00, 8'h00},
        '{8'h7E, 8'hFF, 8'h01, 8'h80},
        '{8'hFC, 8'h00, 8'h00, 8'h00}
    };
    localparam int VEC_N [0:4] = '{1, 2, 2, 4, 1};

    logic clk = 0, rst_n = 0, bit_en = 0;
    logic tx_valid = 0, tx_last = 0, bus_reset_req = 0;
    logic [W-1:0] tx_data = '0;
    logic tx_ready, line_dp_o, line_dm_o, line_oe;
    logic inj = 0, inj_dp = 1, inj_dm = 0;
    logic line_dp_i, line_dm_i;
    logic [W-1:0] rx_data;
    logic rx_valid, rx_sop, rx_eop, rx_stuff_err, rx_active;

    assign line_dp_i = inj ? inj_dp : line_dp_o;
    assign line_dm_i = inj ? inj_dm : line_dm_o;

    diffline_codec #(.DATA_W(W), .RESET_TICKS(RST_T)) i_diffline_codec (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .bus_reset_req(bus_reset_req),
        .line_dp_o(line_dp_o), .line_dm_o(line_dm_o), .line_oe(line_oe),
        .line_dp_i(line_dp_i), .line_dm_i(line_dm_i),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
        .rx_stuff_err(rx_stuff_err), .rx_active(rx_active)
    );

    int n_chk = 0, n_err = 0;
    // monitor state
    logic mon_bits [0:127];
    int   mon_n, mon_se0, mon_run, mon_max, chg_err;
    logic mon_j, mon_prev, mon_on;
    logic [7:0] rx_bytes [0:15];
    int   rx_n, sop_n, eop_n, err_n, acc_n;
    logic ldp, ldm, loe;
    logic exp_bits [0:127];
    int   exp_n;

    initial forever #2.5 clk = ~clk;

    // Bit enable: one cycle in four, changed away from both clock edges.
    initial begin
        int ph;
        ph = 0;
        forever begin
            @(posedge clk); #2;
            bit_en = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_n = 0; mon_se0 = 0; mon_run = 0; mon_max = 0;
        mon_j = 0; mon_prev = 1;
        rx_n = 0; sop_n = 0; eop_n = 0; err_n = 0; acc_n = 0;
    endtask

    // Output monitor, sampled 1 ns after each rising edge.
    initial begin
        chg_err = 0; mon_on = 0; ldp = 1; ldm = 0; loe = 0;
        clear_mon();
        forever begin
            @(posedge clk); #1;
            if (rx_valid) begin
                if (rx_n < 16) rx_bytes[rx_n] = rx_data;
                rx_n++;
            end
            if (rx_sop) sop_n++;
            if (rx_eop) eop_n++;
            if (rx_stuff_err) err_n++;
            if (mon_on && !bit_en && (line_dp_o != ldp || line_dm_o != ldm || line_oe != loe))
                chg_err++;
            ldp = line_dp_o; ldm = line_dm_o; loe = line_oe;
            if (bit_en && line_oe) begin
                if (!line_dp_o && !line_dm_o) mon_se0++;
                else if (mon_se0 == 0) begin
                    if (mon_n < 128) mon_bits[mon_n] = (line_dp_o == mon_prev);
                    mon_run = (line_dp_o == mon_prev) ? mon_run + 1 : 0;
                    if (mon_run > mon_max) mon_max = mon_run;
                    mon_prev = line_dp_o;
                    mon_n++;
                end else mon_j = line_dp_o && !line_dm_o;
            end
        end
    end

    // Expected wire bit stream from R2, R3, R4.
    task automatic build_exp(input int v);
        int run;
        exp_n = 0;
        for (int i = 0; i < 7; i++) begin exp_bits[exp_n] = 0; exp_n++; end
        exp_bits[exp_n] = 1; exp_n++;
        run = 1;
        for (int k = 0; k < VEC_N[v]; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (run == 6) begin exp_bits[exp_n] = 0; exp_n++; run = 0; end
                exp_bits[exp_n] = VEC_B[v][k][b]; exp_n++;
                run = VEC_B[v][k][b] ? run + 1 : 0;
            end
        end
        if (run == 6) begin exp_bits[exp_n] = 0; exp_n++; end
    endtask

    task automatic send_pkt(input int v);
        for (int k = 0; k < VEC_N[v]; k++) begin
            tx_data = VEC_B[v][k];
            tx_last = (k == VEC_N[v] - 1);
            tx_valid = 1;
            do @(negedge clk); while (!tx_ready);
            acc_n++;
            @(posedge clk); #3;
        end
        tx_valid = 0; tx_last = 0;
    endtask

    // Drive one symbol onto the receive wires: 0 toggle, 1 hold, 2 SE0, 3 J.
    task automatic inj_sym(input int kind);
        do @(posedge clk); while (!bit_en);
        @(negedge clk);
        case (kind)
            0: begin inj_dp = ~inj_dp; inj_dm = ~inj_dp; end
            2: begin inj_dp = 0; inj_dm = 0; end
            3: begin inj_dp = 1; inj_dm = 0; end
            default: ;
        endcase
    endtask

    task automatic inj_preamble();
        inj_sym(3); inj_sym(3);
        for (int i = 0; i < 7; i++) inj_sym(0);
        inj_sym(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R12 watchdog: actual %0d cycles expected completion", 150000);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int sync_v, mism;
        repeat (10) @(posedge clk);
        #3 rst_n = 1;
        @(posedge clk); #1;
        // R1: idle after reset
        chk(line_dp_o == 1 && line_dm_o == 0, "R1 idle J", {line_dp_o, line_dm_o}, 2);
        chk(line_oe == 0, "R1 released", line_oe, 0);
        chk(!rx_active && !rx_valid && !rx_sop && !rx_eop && !rx_stuff_err, "R1 rx quiet",
            {rx_active, rx_valid, rx_sop, rx_eop, rx_stuff_err}, 0);
        mon_on = 1;
        @(negedge clk);

        // Table-driven loopback packets
        for (int v = 0; v < NV; v++) begin
            clear_mon();
            build_exp(v);
            send_pkt(v);
            while (line_oe) @(posedge clk);
            repeat (12) @(posedge clk);
            #1;
            sync_v = 0;
            for (int i = 0; i < 8; i++) sync_v = sync_v | (int'(mon_bits[i]) << i);
            chk(sync_v == 8'h80, "R2 preamble", sync_v, 8'h80);
            mism = 0;
            for (int i = 0; i < exp_n && i < 128; i++) if (mon_bits[i] !== exp_bits[i]) mism++;
            chk(mon_n == exp_n, "R3 bit count", mon_n, exp_n);
            chk(mism == 0, "R3 bit stream", mism, 0);
            chk(mon_max <= 6, "R4 run length", mon_max, 6);
            chk(mon_se0 == 2, "R5 SE0 length", mon_se0, 2);
            chk(mon_j == 1, "R5 J after SE0", mon_j, 1);
            chk(line_oe == 0, "R5 release", line_oe, 0);
            chk(acc_n == VEC_N[v], "R7 bytes taken", acc_n, VEC_N[v]);
            chk(sop_n == 1, "R8 sop", sop_n, 1);
            chk(rx_n == VEC_N[v], "R9 byte count", rx_n, VEC_N[v]);
            for (int k = 0; k < VEC_N[v] && k < rx_n; k++)
                chk(rx_bytes[k] == VEC_B[v][k], "R9 byte value", rx_bytes[k], VEC_B[v][k]);
            chk(eop_n == 1, "R10 eop", eop_n, 1);
            chk(err_n == 0, "R11 no error", err_n, 0);
            chk(rx_active == 0, "R10 inactive after eop", rx_active, 0);
            @(negedge clk);
        end

        // R6: bus reset pulse
        clear_mon();
        @(posedge clk); #3 bus_reset_req = 1;
        while (!line_oe) @(posedge clk);
        #3 bus_reset_req = 0;
        while (line_oe) @(posedge clk);
        repeat (8) @(posedge clk); #1;
        chk(mon_se0 == RST_T, "R6 reset length", mon_se0, RST_T);
        chk(line_dp_o == 1 && line_dm_o == 0, "R6 release to J", {line_dp_o, line_dm_o}, 2);
        chk(sop_n == 0 && rx_n == 0, "R6 no packet seen", sop_n + rx_n, 0);

        // R11: injected stuffing violation
        @(negedge clk);
        inj_dp = 1; inj_dm = 0; inj = 1;
        clear_mon();
        inj_preamble();
        for (int i = 0; i < 7; i++) inj_sym(1);
        inj_sym(2); inj_sym(2); inj_sym(3); inj_sym(3); inj_sym(3);
        repeat (8) @(posedge clk); #1;
        chk(sop_n == 1, "R8 sop on injected preamble", sop_n, 1);
        chk(err_n == 1, "R11 stuff error", err_n, 1);
        chk(rx_n == 0, "R11 no partial byte", rx_n, 0);
        chk(eop_n == 0, "R11 packet already left", eop_n, 0);
        chk(rx_active == 0, "R11 inactive", rx_active, 0);

        // R9: injected valid stuffed 0xFF
        @(negedge clk);
        clear_mon();
        inj_preamble();
        for (int i = 0; i < 5; i++) inj_sym(1);
        inj_sym(0);
        for (int i = 0; i < 3; i++) inj_sym(1);
        inj_sym(2); inj_sym(2); inj_sym(3); inj_sym(3); inj_sym(3);
        repeat (8) @(posedge clk); #1;
        chk(rx_n == 1, "R9 stuffed byte count", rx_n, 1);
        chk(rx_n > 0 && rx_bytes[0] == 8'hFF, "R9 stuffed byte value", rx_bytes[0], 8'hFF);
        chk(err_n == 0, "R11 legal stuffing no error", err_n, 0);
        chk(eop_n == 1, "R10 eop injected", eop_n, 1);
        @(negedge clk);
        inj = 0;

        // R12: no line change off a tick
        chk(chg_err == 0, "R12 hold between ticks", chg_err, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule